// File: doc/BRIEF.md
# Converter output formatting pipeline

This block sits between the digital end of a pipelined sampling converter and its parallel result pins. On every sample clock it takes one raw code and two range flags. The flags say whether the analog value fell below zero scale or rose above full scale. After a fixed number of clock edges it presents the finished word together with an over-range indication for that same sample.

On the way, an out-of-range sample is forced to the matching end code. The word can be presented as offset binary or as two's complement, and the result bus can be released to high impedance. A power-down control stops conversion. A data-valid output then stays low through a parameterised wake-up interval, counted in sample clocks, and through the refill of the pipeline with fresh samples. The same holds after reset.

The word width is a parameter. It is normally 10 or 12 bits.

Top module: `conv_out_formatter`

## Requirements
- R1: A sample presented on `code_i`/`lo_i`/`hi_i` before rising edge n appears on `data_o` and `ovr_o` just after rising edge n+3, so four edges are counted including the capture edge (LAT = 4).
- R2: A sample with `lo_i` = 1 yields the unsigned code 0, whatever `code_i` and `hi_i` hold. The low flag has priority.
- R3: A sample with `hi_i` = 1 and `lo_i` = 0 yields the unsigned code with all bits set, which is 1023 at 10 bits.
- R4: `ovr_o` is 1 on exactly the output word of a sample that had `lo_i` or `hi_i` set, and 0 for in-range samples.
- R5: With `twos_sel_i` = 0, the unsigned code passes unchanged. This is the reset state of the bus. With `twos_sel_i` = 1, the most significant bit of the saturated unsigned code is inverted, so unsigned 0 becomes the most negative value. At 10 bits, code 0 becomes 0x200 and 1023 becomes 0x1FF.
- R6: The format is applied at the final register stage, from the value of `twos_sel_i` before that edge. A change made after edge n affects the whole word shown after edge n+1, and no earlier word.
- R7: While `out_dis_i` = 1, every bit of `data_o` is high impedance in the same cycle. The pipeline keeps running, so the bus shows the current word as soon as `out_dis_i` returns to 0.
- R8: While `pwr_dn_i` = 1, `data_o` is high impedance at once. `valid_o` and `ovr_o` are 0 from the first rising edge that samples `pwr_dn_i` high.
- R9: After reset, or after `pwr_dn_i` returns to 0, `valid_o` stays 0 for WAKE_CYC + LAT rising edges and rises at the edge that completes them.
- R10: Once `valid_o` is 1, it stays 1 until a rising edge samples `pwr_dn_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | WIDTH | Raw conversion code |
| lo_i | input | 1 | Sample below zero scale |
| hi_i | input | 1 | Sample above full scale |
| twos_sel_i | input | 1 | 0: unsigned binary, 1: two's complement |
| out_dis_i | input | 1 | 1 releases the data bus to high impedance |
| pwr_dn_i | input | 1 | 1 stops conversion |
| data_o | output | WIDTH | Formatted result word (tri-state) |
| ovr_o | output | 1 | Over-range flag aligned with `data_o` |
| valid_o | output | 1 | Result words are valid |

## Verification
The hardest case to reach from the ports is a format change that lands between two words of a busy pipeline. This is where a word built half in one format and half in the other would show. The stimulus holds an in-range code whose top bit is clear until the pipeline is full, then flips the format bit right after one edge. The bench expects the next word to differ from the previous one in the top bit only.

A second hard-to-reach case is the exact edge on which `valid_o` returns after power-down. A short wake parameter makes it reachable: the bench counts WAKE_CYC + LAT − 1 edges with valid low and then checks that valid is high on the next edge.

// File: rtl/conv_fmt_pkg.sv
package conv_fmt_pkg;
  typedef enum logic {
    FMT_UNSIGNED = 1'b0,
    FMT_TWOS     = 1'b1
  } fmt_e;
endpackage

// File: rtl/conv_sat.sv
module conv_sat #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] code_i,
  input  logic         lo_i,
  input  logic         hi_i,
  output logic [W-1:0] code_o,
  output logic         ovr_o
);
  logic [W-1:0] sat_code;

  always_comb begin
    if (lo_i)      sat_code = '0;
    else if (hi_i) sat_code = '1;
    else           sat_code = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      ovr_o  <= 1'b0;
    end else if (en_i) begin
      code_o <= sat_code;
      ovr_o  <= lo_i | hi_i;
    end
  end
endmodule

// File: rtl/conv_pipe.sv
module conv_pipe #(
  parameter int unsigned W      = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] code_i,
  input  logic         ovr_i,
  output logic [W-1:0] code_o,
  output logic         ovr_o
);
  logic [W:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stg_q[s] <= '0;
        else if (en_i) stg_q[s] <= {ovr_i, code_i};
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stg_q[s] <= '0;
        else if (en_i) stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign code_o = stg_q[STAGES-1][W-1:0];
  assign ovr_o  = stg_q[STAGES-1][W];
endmodule

// File: rtl/conv_wake.sv
module conv_wake #(
  parameter int unsigned WAKE_CYC = 200000,
  parameter int unsigned LAT      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  output logic valid_o
);
  localparam int unsigned WW = $clog2(WAKE_CYC + 1);
  localparam int unsigned FW = $clog2(LAT + 1);

  logic [WW-1:0] wake_q;
  logic [FW-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= '0;
      fill_q <= '0;
    end else if (pd_i) begin
      wake_q <= '0;
      fill_q <= '0;
    end else if (wake_q != WW'(WAKE_CYC)) begin
      wake_q <= wake_q + 1'b1;
    end else if (fill_q != FW'(LAT)) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  assign valid_o = (fill_q == FW'(LAT));
endmodule

// File: rtl/conv_out_formatter.sv
module conv_out_formatter
  import conv_fmt_pkg::*;
#(
  parameter int unsigned WIDTH    = 10,
  parameter int unsigned LAT      = 4,
  parameter int unsigned WAKE_CYC = 200000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] code_i,
  input  logic             lo_i,
  input  logic             hi_i,
  input  logic             twos_sel_i,
  input  logic             out_dis_i,
  input  logic             pwr_dn_i,
  output logic [WIDTH-1:0] data_o,
  output logic             ovr_o,
  output logic             valid_o
);
  localparam int unsigned MID = LAT - 2;
  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  logic             run;
  logic [WIDTH-1:0] sat_code, mid_code, out_word_q;
  logic             sat_ovr, mid_ovr, out_ovr_q;
  fmt_e             fmt;

  assign run = ~pwr_dn_i;
  assign fmt = fmt_e'(twos_sel_i);

  conv_sat #(.W(WIDTH)) u_sat (
    .clk_i, .rst_ni, .en_i(run),
    .code_i, .lo_i, .hi_i,
    .code_o(sat_code), .ovr_o(sat_ovr)
  );

  conv_pipe #(.W(WIDTH), .STAGES(MID)) u_pipe (
    .clk_i, .rst_ni, .en_i(run),
    .code_i(sat_code), .ovr_i(sat_ovr),
    .code_o(mid_code), .ovr_o(mid_ovr)
  );

  conv_wake #(.WAKE_CYC(WAKE_CYC), .LAT(LAT)) u_wake (
    .clk_i, .rst_ni, .pd_i(pwr_dn_i), .valid_o
  );

  // format applied to the whole word at the last stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_word_q <= '0;
      out_ovr_q  <= 1'b0;
    end else if (run) begin
      out_word_q <= (fmt == FMT_TWOS) ? (mid_code ^ MSB_MASK) : mid_code;
      out_ovr_q  <= mid_ovr;
    end
  end

  assign ovr_o  = out_ovr_q & valid_o;
  assign data_o = (out_dis_i || pwr_dn_i) ? {WIDTH{1'bz}} : out_word_q;
endmodule

// File: rtl/conv_out_formatter_chk.sv
module conv_out_formatter_chk #(
  parameter int unsigned W = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         pwr_dn_i,
  input logic         out_dis_i,
  input logic [W-1:0] data_o,
  input logic         ovr_o,
  input logic         valid_o
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  p_pd_drops_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> !valid_o);

  p_valid_rise_after_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> !$past(pwr_dn_i));

  p_valid_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pwr_dn_i) |=> valid_o);

  p_ovr_end_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !out_dis_i && !pwr_dn_i) |->
      (data_o == '0 || data_o == '1 || data_o == MSB_ONLY || data_o == ~MSB_ONLY));
endmodule

bind conv_out_formatter conv_out_formatter_chk #(.W(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_dn_i(pwr_dn_i), .out_dis_i(out_dis_i),
  .data_o(data_o), .ovr_o(ovr_o), .valid_o(valid_o)
);

// File: tb/conv_out_formatter_test.sv
module conv_out_formatter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 10;
  localparam int LAT  = 4;
  localparam int WAKE = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] code = '0;
  logic         lo = 1'b0, hi = 1'b0, twos = 1'b0, odis = 1'b0, pd = 1'b0;
  wire  [W-1:0] data;
  logic         ovr, valid;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_out_formatter #(.WIDTH(W), .LAT(LAT), .WAKE_CYC(WAKE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code), .lo_i(lo), .hi_i(hi),
    .twos_sel_i(twos), .out_dis_i(odis), .pwr_dn_i(pd),
    .data_o(data), .ovr_o(ovr), .valid_o(valid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W-1:0] exp_word(logic [W-1:0] c, logic l, logic h, logic t);
    logic [W-1:0] r;
    r = l ? '0 : (h ? '1 : c);
    if (t) r[W-1] = ~r[W-1];
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    tick(); tick();
    rst_n = 1'b1;
    chk1("R9 reset valid", valid, 1'b0);
    chk1("R4 reset ovr", ovr, 1'b0);
    chk("R5 reset bus", data, '0);
    for (int i = 0; i < WAKE + LAT - 1; i++) tick();
    chk1("R9 valid still low", valid, 1'b0);
    tick();
    chk1("R9 valid rises", valid, 1'b1);
  endtask

  task automatic t_stream(logic tw);
    logic [W-1:0] c [8];
    logic l [8];
    logic h [8];
    c = '{10'h155, 10'h2AA, 10'h3F0, 10'h001, 10'h200, 10'h07F, 10'h3FF, 10'h000};
    l = '{0, 1, 0, 1, 0, 0, 0, 1};
    h = '{0, 0, 1, 1, 0, 1, 0, 0};
    twos = tw;
    for (int i = 0; i < 8 + 3; i++) begin
      if (i < 8) begin code = c[i]; lo = l[i]; hi = h[i]; end
      tick();
      if (i >= 3) begin
        // R1 R2 R3 R5: word four edges later
        chk(tw ? "R1/R5 twos word" : "R1/R2/R3 word", data,
            exp_word(c[i-3], l[i-3], h[i-3], tw));
        chk1("R4 ovr aligned", ovr, l[i-3] | h[i-3]);
      end
    end
    lo = 0; hi = 0;
  endtask

  task automatic t_format_switch();
    logic [W-1:0] prev;
    twos = 0; code = 10'h0AA;
    for (int i = 0; i < LAT + 1; i++) tick();
    prev = data;
    chk("R6 before switch", prev, 10'h0AA);
    twos = 1;
    chk("R6 no change before edge", data, 10'h0AA);
    tick();
    chk("R6 whole word switched", data, 10'h2AA);
    twos = 0;
    tick();
    chk("R6 switch back", data, 10'h0AA);
  endtask

  task automatic t_out_dis();
    odis = 1;
    #1;
    chk("R7 bus high-z", data, {W{1'bz}});
    code = 10'h123;
    for (int i = 0; i < LAT; i++) tick();
    chk("R7 still high-z", data, {W{1'bz}});
    chk1("R7 valid kept", valid, 1'b1);
    odis = 0;
    #1;
    chk("R7 pipeline ran", data, 10'h123);
  endtask

  task automatic t_power_down();
    code = 10'h3FF; hi = 1;
    for (int i = 0; i < LAT; i++) tick();
    chk1("R4 ovr before pd", ovr, 1'b1);
    pd = 1;
    #1;
    chk("R8 bus high-z", data, {W{1'bz}});
    tick();
    chk1("R8 valid low", valid, 1'b0);
    chk1("R8 ovr low", ovr, 1'b0);
    tick(); tick();
    hi = 0; code = 10'h042;
    pd = 0;
    for (int i = 0; i < WAKE + LAT - 1; i++) tick();
    chk1("R9 valid low during wake", valid, 1'b0);
    tick();
    chk1("R9 valid back", valid, 1'b1);
    chk("R9 fresh word", data, 10'h042);
    for (int i = 0; i < 20; i++) tick();
    chk1("R10 valid held", valid, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_stream(1'b0);
    t_stream(1'b1);
    t_format_switch();
    t_out_dis();
    t_power_down();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule